// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small microprogrammed processor. It holds a 64-word control store and a 6-bit micro-address register. From reset it steps through a shared four-word instruction-fetch routine. The last fetch word dispatches to a microroutine whose control-store address equals the 5-bit opcode taken from the instruction register.

Each microword carries several fields:
- a micro-op code;
- three bus-routing fields: source one, source two and destination;
- an ALU function;
- two memory-control fields;
- two candidate successor addresses.

For an ordinary microword, the condition input picks one of the two successors. A microword whose second memory field holds the wait code keeps the micro-address in place until memory reports ready. The control fields of the current word drive the outputs directly. The datapath, the register file, the ALU and main memory sit outside the block.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset, sampled at a rising edge, sets the micro-address to 0x20.
- R2: The fetch routine visits 0x20, 0x21, 0x22 and 0x23 in that order, whatever the condition input is.
- R3: The output fields are listed as {uop, bus1, bus2, bus3, alu, mem1, mem2}. Word 0x20 outputs {0,1,0,2,1,0,8}, where mem2 = 8 starts a memory read. Word 0x21 outputs {0,1,1,1,5,0,0}. Word 0x22 outputs {0,0,6,4,2,0,0}.
- R4: Word 0x23 has uop = 1 (dispatch) and all other fields 0. The next micro-address is the 5-bit opcode with a zero bit prepended.
- R5: Word 0x02 (AND immediate) outputs {0,4,3,3,7,0,0}. It returns to 0x20 for either condition value.
- R6: Word 0x0D (store) outputs {0,4,3,2,5,0,0}. It goes to 0x35 when cond = 0 and to 0x32 when cond = 1.
- R7: The indirection path runs 0x32, then 0x33, then 0x34, then 0x35. Word 0x32 has mem2 = 8 (read). Word 0x33 has mem2 = 4 (wait). Word 0x34 outputs {0,0,6,2,2,0,0}.
- R8: While the current word has mem2 = 4 and mem_ready is 0, the micro-address holds and the condition input is ignored. Once mem_ready is 1, the sequencer moves to the word's successor.
- R9: Every location not named in R3 to R11 outputs all-zero fields and goes to 0x20 for either condition value. This applies to dispatch targets of unused opcodes.
- R10: The micro-address changes only at a rising clock edge. Changing opcode, cond or mem_ready between edges leaves every output unchanged.
- R11: Word 0x35 has mem2 = 2 (write start) and all other fields 0, and goes to 0x36. Word 0x36 has mem2 = 4 (wait) and then goes to 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 5 | Opcode from the instruction register |
| cond | input | 1 | Selects the successor: 0 picks field zero, 1 picks field one |
| mem_ready | input | 1 | Memory has completed the access |
| upc | output | 6 | Current micro-address |
| uop | output | 2 | Micro-op code (1 = dispatch) |
| bus1 | output | 3 | First source-bus select |
| bus2 | output | 3 | Second source-bus select |
| bus3 | output | 3 | Destination-bus select |
| alu_fn | output | 3 | ALU function |
| mem1 | output | 2 | First memory-control field |
| mem2 | output | 4 | Second memory-control field (8 read, 2 write, 4 wait) |

## Verification
The bench stalls the sequencer in both wait words with mem_ready low for several cycles while it toggles cond. A design that leaked through the stall would move on early or take the wrong branch. It dispatches to the defined opcodes and to unused ones. A wrong dispatch width or a non-returning default word would strand the sequencer outside the fetch loop. It drives both store branches, asserts reset in the middle of the fetch routine, and changes inputs between edges, which exposes outputs that depend on the inputs combinationally.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int UA_W   = 6;
    localparam int OPC_W  = 5;
    localparam int BUS_W  = 3;
    localparam int ALU_W  = 3;
    localparam int M1_W   = 2;
    localparam int M2_W   = 4;
    localparam int UOP_W  = 2;
    localparam int DEPTH  = 2 ** UA_W;

    localparam logic [UA_W-1:0] FETCH_ENTRY = 6'h20;

    localparam logic [M2_W-1:0] MEM_NONE  = 4'd0;
    localparam logic [M2_W-1:0] MEM_WRITE = 4'd2;
    localparam logic [M2_W-1:0] MEM_WAIT  = 4'd4;
    localparam logic [M2_W-1:0] MEM_READ  = 4'd8;

    typedef enum logic [UOP_W-1:0] {
        UOP_SEQ      = 2'd0,
        UOP_DISPATCH = 2'd1
    } uop_e;

    typedef struct packed {
        uop_e              uop;
        logic [BUS_W-1:0]  b1;
        logic [BUS_W-1:0]  b2;
        logic [BUS_W-1:0]  b3;
        logic [ALU_W-1:0]  alu;
        logic [M1_W-1:0]   m1;
        logic [M2_W-1:0]   m2;
        logic [UA_W-1:0]   nxt0;
        logic [UA_W-1:0]   nxt1;
    } uword_t;

    typedef struct packed {
        logic [UA_W-1:0] upc;
    } seq_state_t;

    function automatic uword_t mk_word(
        input uop_e             op,
        input logic [BUS_W-1:0] b1,
        input logic [BUS_W-1:0] b2,
        input logic [BUS_W-1:0] b3,
        input logic [ALU_W-1:0] alu,
        input logic [M1_W-1:0]  m1,
        input logic [M2_W-1:0]  m2,
        input logic [UA_W-1:0]  n0,
        input logic [UA_W-1:0]  n1
    );
        uword_t w;
        w.uop  = op;
        w.b1   = b1;
        w.b2   = b2;
        w.b3   = b3;
        w.alu  = alu;
        w.m1   = m1;
        w.m2   = m2;
        w.nxt0 = n0;
        w.nxt1 = n1;
        return w;
    endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uword_t          word
);
    always_comb begin
        word = mk_word(UOP_SEQ, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, MEM_NONE,
                       FETCH_ENTRY, FETCH_ENTRY);
        case (addr)
            6'h20: word = mk_word(UOP_SEQ, 3'd1, 3'd0, 3'd2, 3'd1, 2'd0, MEM_READ,  6'h21, 6'h21);
            6'h21: word = mk_word(UOP_SEQ, 3'd1, 3'd1, 3'd1, 3'd5, 2'd0, MEM_NONE,  6'h22, 6'h22);
            6'h22: word = mk_word(UOP_SEQ, 3'd0, 3'd6, 3'd4, 3'd2, 2'd0, MEM_NONE,  6'h23, 6'h23);
            6'h23: word = mk_word(UOP_DISPATCH, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, MEM_NONE, 6'h20, 6'h20);
            6'h02: word = mk_word(UOP_SEQ, 3'd4, 3'd3, 3'd3, 3'd7, 2'd0, MEM_NONE,  6'h20, 6'h20);
            6'h0D: word = mk_word(UOP_SEQ, 3'd4, 3'd3, 3'd2, 3'd5, 2'd0, MEM_NONE,  6'h35, 6'h32);
            6'h32: word = mk_word(UOP_SEQ, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, MEM_READ,  6'h33, 6'h33);
            6'h33: word = mk_word(UOP_SEQ, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, MEM_WAIT,  6'h34, 6'h34);
            6'h34: word = mk_word(UOP_SEQ, 3'd0, 3'd6, 3'd2, 3'd2, 2'd0, MEM_NONE,  6'h35, 6'h35);
            6'h35: word = mk_word(UOP_SEQ, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, MEM_WRITE, 6'h36, 6'h36);
            6'h36: word = mk_word(UOP_SEQ, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, MEM_WAIT,  6'h20, 6'h20);
            default: ;
        endcase
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  uword_t           word,
    input  logic [UA_W-1:0]  cur,
    input  logic [OPC_W-1:0] opcode,
    input  logic             cond,
    input  logic             mem_ready,
    output logic [UA_W-1:0]  nxt
);
    localparam int PAD_W = UA_W - OPC_W;

    logic stall;

    always_comb begin
        stall = (word.m2 == MEM_WAIT) && !mem_ready;
        if (stall)
            nxt = cur;
        else if (word.uop == UOP_DISPATCH)
            nxt = {{PAD_W{1'b0}}, opcode};
        else if (cond)
            nxt = word.nxt1;
        else
            nxt = word.nxt0;
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              cond,
    input  logic              mem_ready,
    output logic [UA_W-1:0]   upc,
    output logic [UOP_W-1:0]  uop,
    output logic [BUS_W-1:0]  bus1,
    output logic [BUS_W-1:0]  bus2,
    output logic [BUS_W-1:0]  bus3,
    output logic [ALU_W-1:0]  alu_fn,
    output logic [M1_W-1:0]   mem1,
    output logic [M2_W-1:0]   mem2
);
    localparam int PAD_W = UA_W - OPC_W;

    seq_state_t      st_d, st_q;
    uword_t          cur_word;
    logic [UA_W-1:0] succ;

    useq_store u_store (
        .addr (st_q.upc),
        .word (cur_word)
    );

    useq_next u_next (
        .word      (cur_word),
        .cur       (st_q.upc),
        .opcode    (opcode),
        .cond      (cond),
        .mem_ready (mem_ready),
        .nxt       (succ)
    );

    always_comb begin
        st_d = st_q;
        if (rst)
            st_d.upc = FETCH_ENTRY;
        else
            st_d.upc = succ;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign upc    = st_q.upc;
    assign uop    = cur_word.uop;
    assign bus1   = cur_word.b1;
    assign bus2   = cur_word.b2;
    assign bus3   = cur_word.b3;
    assign alu_fn = cur_word.alu;
    assign mem1   = cur_word.m1;
    assign mem2   = cur_word.m2;

    // R1
    reset_entry_chk: assert property (@(posedge clk)
        rst |=> (upc == FETCH_ENTRY));

    // R2
    fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
        (upc == FETCH_ENTRY) |=> (upc == 6'h21));

    // R4
    dispatch_target_chk: assert property (@(posedge clk) disable iff (rst)
        (uop == UOP_DISPATCH) |=> (upc == {{PAD_W{1'b0}}, $past(opcode)}));

    // R8
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((mem2 == MEM_WAIT) && !mem_ready) |=> $stable(upc));

    // R6
    store_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (upc == 6'h0D) |=> (upc == ($past(cond) ? 6'h32 : 6'h35)));
endmodule

// File: tb/useq_top_test.sv
module useq_top_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] opcode;
    logic       cond;
    logic       mem_ready;
    logic [5:0] upc;
    logic [1:0] uop;
    logic [2:0] bus1, bus2, bus3, alu_fn;
    logic [1:0] mem1;
    logic [3:0] mem2;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    logic [5:0] exp_upc;

    always #(PERIOD/2) clk = ~clk;

    useq_top uut (
        .clk(clk), .rst(rst), .opcode(opcode), .cond(cond), .mem_ready(mem_ready),
        .upc(upc), .uop(uop), .bus1(bus1), .bus2(bus2), .bus3(bus3),
        .alu_fn(alu_fn), .mem1(mem1), .mem2(mem2)
    );

    // {uop, bus1, bus2, bus3, alu, mem1, mem2}
    function automatic logic [19:0] exp_ctl(input logic [5:0] a);
        case (a)
            6'h20: return {2'd0, 3'd1, 3'd0, 3'd2, 3'd1, 2'd0, 4'd8};
            6'h21: return {2'd0, 3'd1, 3'd1, 3'd1, 3'd5, 2'd0, 4'd0};
            6'h22: return {2'd0, 3'd0, 3'd6, 3'd4, 3'd2, 2'd0, 4'd0};
            6'h23: return {2'd1, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, 4'd0};
            6'h02: return {2'd0, 3'd4, 3'd3, 3'd3, 3'd7, 2'd0, 4'd0};
            6'h0D: return {2'd0, 3'd4, 3'd3, 3'd2, 3'd5, 2'd0, 4'd0};
            6'h32: return {2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, 4'd8};
            6'h33: return {2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, 4'd4};
            6'h34: return {2'd0, 3'd0, 3'd6, 3'd2, 3'd2, 2'd0, 4'd0};
            6'h35: return {2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, 4'd2};
            6'h36: return {2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, 4'd4};
            default: return 20'd0;
        endcase
    endfunction

    function automatic logic [5:0] exp_next(input logic [5:0] a, input logic [4:0] op,
                                            input logic c, input logic rdy);
        if ((a == 6'h33 || a == 6'h36) && !rdy) return a;
        case (a)
            6'h20: return 6'h21;
            6'h21: return 6'h22;
            6'h22: return 6'h23;
            6'h23: return {1'b0, op};
            6'h0D: return c ? 6'h32 : 6'h35;
            6'h32: return 6'h33;
            6'h33: return 6'h34;
            6'h34: return 6'h35;
            6'h35: return 6'h36;
            default: return 6'h20;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            6'h20, 6'h22: return "R3";
            6'h21: return "R2";
            6'h23: return "R4";
            6'h02: return "R5";
            6'h0D: return "R6";
            6'h32, 6'h33, 6'h34: return "R7";
            6'h35, 6'h36: return "R11";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [19:0] act_ctl();
        return {uop, bus1, bus2, bus3, alu_fn, mem1, mem2};
    endfunction

    task automatic step(input logic r, input logic [4:0] op, input logic c, input logic rdy);
        string t;
        logic [5:0] prev;
        prev = exp_upc;
        rst = r; opcode = op; cond = c; mem_ready = rdy;
        #1;
        // R10: inputs changed between edges must not move outputs
        chk(upc == prev, "R10", upc, prev);
        chk(act_ctl() == exp_ctl(prev), "R10", act_ctl(), exp_ctl(prev));
        if (r) begin
            exp_upc = 6'h20; t = "R1";
        end else begin
            exp_upc = exp_next(prev, op, c, rdy);
            if ((prev == 6'h33 || prev == 6'h36) && !rdy) t = "R8";
            else if (prev == 6'h20 || prev == 6'h22) t = "R2";
            else t = tag_of(prev);
        end
        @(posedge clk);
        @(negedge clk);
        chk(upc == exp_upc, t, upc, exp_upc);
        chk(act_ctl() == exp_ctl(exp_upc), tag_of(exp_upc), act_ctl(), exp_ctl(exp_upc));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst = 1'b1; opcode = 5'd0; cond = 1'b0; mem_ready = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        exp_upc = 6'h20;
        chk(upc == 6'h20, "R1", upc, 6'h20);
        chk(act_ctl() == exp_ctl(6'h20), "R3", act_ctl(), exp_ctl(6'h20));

        // R2/R5: fetch with toggling cond, AND immediate
        step(0, 5'h02, 1, 1); step(0, 5'h02, 0, 0); step(0, 5'h02, 1, 0); step(0, 5'h02, 0, 1);
        step(0, 5'h02, 1, 1); // leaves 0x02 with cond=1
        // R6/R7/R8: store with indirection, stalls at both wait words
        step(0, 5'h0D, 0, 1); step(0, 5'h0D, 1, 1); step(0, 5'h0D, 0, 1); step(0, 5'h0D, 0, 1);
        step(0, 5'h0D, 1, 0); step(0, 5'h0D, 1, 0);
        for (int i = 0; i < 4; i++) step(0, 5'h0D, i[0], 0);
        step(0, 5'h0D, 0, 1);
        step(0, 5'h0D, 1, 0); step(0, 5'h0D, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 5'h0D, i[0], 0);
        step(0, 5'h0D, 1, 1);
        // R6: store without indirection
        for (int i = 0; i < 4; i++) step(0, 5'h0D, 0, 1);
        step(0, 5'h0D, 0, 1); step(0, 5'h0D, 0, 1); step(0, 5'h0D, 1, 1);
        // R9: unused opcode
        for (int i = 0; i < 6; i++) step(0, 5'h1F, 1, 1);
        // R1: reset mid-fetch
        step(0, 5'h02, 0, 1); step(0, 5'h02, 0, 1); step(1, 5'h02, 1, 1);
        step(0, 5'h02, 0, 1);

        for (int i = 0; i < 3000; i++) begin
            logic [4:0] op;
            int sel;
            sel = $urandom % 4;
            op = (sel == 0) ? 5'h02 : (sel == 1) ? 5'h0D : 5'($urandom % 32);
            step(($urandom % 200) == 0, op, 1'($urandom % 2), ($urandom % 4) != 0);
        end
        summary();
    end
endmodule